// File: doc/BRIEF.md
# Event-Triggered Delay and Gate Unit

This block turns decoded 8-bit timing events into precisely placed output pulses. It owns eight delay channels, grouped as four pairs. Each pair holds one trigger code and one control word, and each channel holds its own 16-bit delay. When an event strobe carries the code stored for a pair, every enabled channel of that pair starts counting its delay. The count runs either on every clock cycle (about 110 ns at the intended 9 MHz timing clock) or on a 1 MHz tick enable. When the count expires, the channel emits a pulse that lasts one of three selectable lengths.

The third and fourth channel of each group of four can be chained. A chained channel ignores the event match and starts from the firing of the channel two positions below it, so a second delay can follow the first. Four gate outputs turn two channels into a long window: a gate opens when a fixed "set" channel pulses and closes when a fixed "clear" channel pulses. A write port loads the trigger codes, control words and delays.

Top module: `evt_delay_gate_unit`

## Requirements
- R1: After reset every pulse and gate output is low, and every channel is disabled, so no event starts a channel until software enables it.
- R2: Writes address a register by `wr_addr[4:3]` (00 trigger code, 01 pair control, 10 channel delay) and `wr_addr[2:0]` (pair or channel index). A trigger code is taken from `wr_data[7:0]`; higher bits of that word have no effect on matching.
- R3: A strobe whose code equals a pair's trigger code starts every enabled, unchained channel of that pair; a strobe with any other code starts nothing.
- R4: With the timebase bit clear, a channel with delay D started by a strobe sampled at clock edge S raises its pulse after edge S+D+1 (a delay of 0 fires on the first step after the start).
- R5: With the timebase bit set, the delay counts only cycles where `us_tick` is high: the pulse rises after the edge that samples the (D+1)-th tick following the start edge.
- R6: The pair control word holds, for the even channel in bits 4:0 and for the odd channel in bits 12:8, the fields: bit 0 enable, bit 1 timebase, bits 3:2 length, bit 4 chain. Length 00 gives a 1-cycle pulse, 01 gives 7 cycles, 10 gives 73 cycles, 11 behaves as 00.
- R7: A new start while a channel is counting or pulsing restarts its delay from the full value, so only the last start produces a pulse.
- R8: Channels 2, 3, 6 and 7 with the chain bit set start on the cycle their source channel (0, 1, 4, 5 respectively) fires, ignoring event matches, so the chained pulse rises D+1 steps after the source pulse rises.
- R9: Gate g opens one cycle after its set channel pulses and closes one cycle after its clear channel pulses (gate 0: 0 sets / 2 clears; gate 1: 1/3; gate 2: 4/6; gate 3: 5/7); when both pulse together, the gate ends closed.
- R10: Clearing a channel's enable stops it at once, and a disabled channel ignores matching events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one fast timebase step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| us_tick | input | 1 | One-cycle enable at 1 MHz for the slow timebase |
| evt_valid | input | 1 | Strobe: `evt_code` holds a decoded event this cycle |
| evt_code | input | 8 | Decoded event code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register kind (4:3) and index (2:0) |
| wr_data | input | 16 | Register write data |
| pulse_o | output | 8 | Delayed pulse outputs, one per channel |
| gate_o | output | 4 | Gate outputs |

## Verification
Each result has a fixed due cycle counted from the edge that samples the strobe: a fast-timebase pulse rises D+1 edges later and falls after its length, a slow-timebase pulse rises on the edge of the (D+1)-th tick past the start, a chained pulse rises D+1 edges after its source rises, and a gate moves one edge after the pulse that sets or clears it. The driver records the sampling edge of every strobe it sends and queues each expected rising and falling edge with its absolute cycle number; the monitor samples at the falling clock edge, matches every observed output edge against the queue and compares cycle numbers, so an early, late, missing or extra pulse is reported. Gate levels are predicted every cycle from the expected pulse intervals alone and compared at the same sampling point.

// File: rtl/evtdg_pkg.sv
package evtdg_pkg;

  localparam int CODE_W = 8;
  localparam int WORD_W = 16;

  // register kinds selected by the top two address bits
  localparam logic [1:0] KIND_CODE = 2'b00;
  localparam logic [1:0] KIND_CTRL = 2'b01;
  localparam logic [1:0] KIND_DLY  = 2'b10;

  typedef enum logic [1:0] {
    LEN_SHORT = 2'b00,
    LEN_MID   = 2'b01,
    LEN_LONG  = 2'b10,
    LEN_RSVD  = 2'b11
  } len_sel_e;

  // per-channel configuration field, LSB first: enable, timebase, length, chain
  typedef struct packed {
    logic     chain;
    len_sel_e len_sel;
    logic     slow_tb;
    logic     enable;
  } ch_cfg_t;

  localparam int CFG_W      = $bits(ch_cfg_t);
  localparam int CFG_EV_LSB = 0;
  localparam int CFG_OD_LSB = 8;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'b00,
    CH_COUNT = 2'b01,
    CH_PULSE = 2'b10
  } ch_state_e;

endpackage

// File: rtl/evtdg_regs.sv
module evtdg_regs
  import evtdg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DLY_W  = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  logic [1+$clog2(NUM_CH):0]       wr_addr_i,
  input  logic [WORD_W-1:0]               wr_data_i,
  output logic [NUM_CH/2-1:0][CODE_W-1:0] code_o,
  output ch_cfg_t [NUM_CH-1:0]            cfg_o,
  output logic [NUM_CH-1:0][DLY_W-1:0]    dly_o
);

  localparam int NUM_PAIRS = NUM_CH / 2;
  localparam int IDX_W     = $clog2(NUM_CH);
  localparam int ADDR_W    = IDX_W + 2;

  logic [NUM_PAIRS-1:0][CODE_W-1:0] code_q, code_d;
  ch_cfg_t [NUM_CH-1:0]             cfg_q, cfg_d;
  logic [NUM_CH-1:0][DLY_W-1:0]     dly_q, dly_d;

  logic [1:0]       kind;
  logic [IDX_W-1:0] idx;
  logic             unused_wdata;

  assign kind         = wr_addr_i[ADDR_W-1 -: 2];
  assign idx          = wr_addr_i[IDX_W-1:0];
  assign unused_wdata = ^wr_data_i;

  always_comb begin
    code_d = code_q;
    cfg_d  = cfg_q;
    dly_d  = dly_q;
    if (wr_en_i) begin
      unique case (kind)
        KIND_CODE: begin
          for (int p = 0; p < NUM_PAIRS; p++) begin
            if (idx == IDX_W'(p)) code_d[p] = wr_data_i[CODE_W-1:0];
          end
        end
        KIND_CTRL: begin
          for (int p = 0; p < NUM_PAIRS; p++) begin
            if (idx == IDX_W'(p)) begin
              cfg_d[2*p]   = ch_cfg_t'(wr_data_i[CFG_EV_LSB +: CFG_W]);
              cfg_d[2*p+1] = ch_cfg_t'(wr_data_i[CFG_OD_LSB +: CFG_W]);
            end
          end
        end
        KIND_DLY: begin
          for (int c = 0; c < NUM_CH; c++) begin
            if (idx == IDX_W'(c)) dly_d[c] = wr_data_i[DLY_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cfg_q  <= '0;
      dly_q  <= '0;
    end else begin
      code_q <= code_d;
      cfg_q  <= cfg_d;
      dly_q  <= dly_d;
    end
  end

  assign code_o = code_q;
  assign cfg_o  = cfg_q;
  assign dly_o  = dly_q;

endmodule

// File: rtl/evtdg_channel.sv
module evtdg_channel
  import evtdg_pkg::*;
#(
  parameter int DLY_W         = 16,
  parameter int LEN_SHORT_CYC = 1,
  parameter int LEN_MID_CYC   = 7,
  parameter int LEN_LONG_CYC  = 73
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick_i,
  input  ch_cfg_t          cfg_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             start_i,
  output logic             pulse_o,
  output logic             fire_o
);

  localparam int LEN_W = $clog2(LEN_LONG_CYC + 1);
  localparam int CNT_W = (DLY_W > LEN_W) ? DLY_W : LEN_W;

  ch_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_load;
  logic             step;
  logic             unused_chain;

  assign unused_chain = cfg_i.chain;
  assign step         = cfg_i.slow_tb ? us_tick_i : 1'b1;

  always_comb begin
    unique case (cfg_i.len_sel)
      LEN_MID:  len_load = CNT_W'(LEN_MID_CYC - 1);
      LEN_LONG: len_load = CNT_W'(LEN_LONG_CYC - 1);
      default:  len_load = CNT_W'(LEN_SHORT_CYC - 1);
    endcase
  end

  // one counter serves the delay phase and then the pulse-width phase
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fire_o  = 1'b0;
    if (!cfg_i.enable) begin
      state_d = CH_IDLE;
    end else if (start_i) begin
      state_d = CH_COUNT;
      cnt_d   = CNT_W'(dly_i);
    end else begin
      unique case (state_q)
        CH_COUNT: begin
          if (step) begin
            if (cnt_q == '0) begin
              state_d = CH_PULSE;
              cnt_d   = len_load;
              fire_o  = 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        CH_PULSE: begin
          if (cnt_q == '0) state_d = CH_IDLE;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse_o = (state_q == CH_PULSE);

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.enable && start_i) |=> !pulse_o); // R7

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.enable |=> !pulse_o); // R10

  AST_RISE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(step && cfg_i.enable)); // R5

endmodule

// File: rtl/evtdg_gate.sv
module evtdg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic gate_o
);

  logic gate_q, gate_d;

  always_comb begin
    gate_d = gate_q;
    if (clr_i)      gate_d = 1'b0;
    else if (set_i) gate_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  assign gate_o = gate_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !gate_o); // R9

  AST_SET_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> gate_o); // R9

endmodule

// File: rtl/evt_delay_gate_unit.sv
module evt_delay_gate_unit
  import evtdg_pkg::*;
#(
  parameter int NUM_GROUPS    = 2,
  parameter int DLY_W         = 16,
  parameter int LEN_SHORT_CYC = 1,
  parameter int LEN_MID_CYC   = 7,
  parameter int LEN_LONG_CYC  = 73
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                us_tick,
  input  logic                                evt_valid,
  input  logic [7:0]                          evt_code,
  input  logic                                wr_en,
  input  logic [1+$clog2(4*NUM_GROUPS):0]     wr_addr,
  input  logic [15:0]                         wr_data,
  output logic [4*NUM_GROUPS-1:0]             pulse_o,
  output logic [2*NUM_GROUPS-1:0]             gate_o
);

  localparam int NUM_CH    = 4 * NUM_GROUPS;
  localparam int NUM_PAIRS = NUM_CH / 2;
  localparam int NUM_GATES = 2 * NUM_GROUPS;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_PAIRS-1:0][CODE_W-1:0] code;
  ch_cfg_t [NUM_CH-1:0]             cfg;
  logic [NUM_CH-1:0][DLY_W-1:0]     dly;
  logic [NUM_CH-1:0]                start;
  logic [NUM_CH-1:0]                fire;
  logic                             unused_fire;

  assign unused_fire = ^fire;

  evtdg_regs #(
    .NUM_CH (NUM_CH),
    .DLY_W  (DLY_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .code_o    (code),
    .cfg_o     (cfg),
    .dly_o     (dly)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic match;
    assign match = evt_valid && (evt_code == code[c/2]);

    if ((c % 4) >= 2) begin : g_chainable
      assign start[c] = cfg[c].chain ? fire[c-2] : match;
    end else begin : g_plain
      logic unused_chain;
      assign unused_chain = cfg[c].chain;
      assign start[c]     = match;
    end

    evtdg_channel #(
      .DLY_W         (DLY_W),
      .LEN_SHORT_CYC (LEN_SHORT_CYC),
      .LEN_MID_CYC   (LEN_MID_CYC),
      .LEN_LONG_CYC  (LEN_LONG_CYC)
    ) chan_i (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .us_tick_i (us_tick),
      .cfg_i     (cfg[c]),
      .dly_i     (dly[c]),
      .start_i   (start[c]),
      .pulse_o   (pulse_o[c]),
      .fire_o    (fire[c])
    );
  end

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    localparam int SET_CH = 4 * (g / 2) + (g % 2);
    localparam int CLR_CH = SET_CH + 2;

    evtdg_gate gate_i (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .set_i  (pulse_o[SET_CH]),
      .clr_i  (pulse_o[CLR_CH]),
      .gate_o (gate_o[g])
    );
  end

endmodule

// File: tb/evt_delay_gate_unit_tb_top.sv
module evt_delay_gate_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        us_tick;
  logic        evt_valid;
  logic [7:0]  evt_code;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  pulse_o;
  logic [3:0]  gate_o;

  always #4 clk = ~clk;

  evt_delay_gate_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick   (us_tick),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pulse_o   (pulse_o),
    .gate_o    (gate_o)
  );

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int cyc; int ch; bit val; string req; } exp_t;
  typedef struct { int ch; int rise; int fall; } ivl_t;
  exp_t sbq[$];
  ivl_t ivls[$];

  function automatic bit exp_high(int ch, int c);
    foreach (ivls[i]) if (ivls[i].ch == ch && c >= ivls[i].rise && c < ivls[i].fall) return 1'b1;
    return 1'b0;
  endfunction

  task automatic expect_pulse(int ch, int rise, int len, string req);
    exp_t e;
    ivl_t v;
    e.ch = ch; e.req = req;
    e.cyc = rise; e.val = 1'b1; sbq.push_back(e);
    e.cyc = rise + len; e.val = 1'b0; sbq.push_back(e);
    v.ch = ch; v.rise = rise; v.fall = rise + len;
    ivls.push_back(v);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // monitor: pulse edges against the queue, gate levels against a model
  logic [7:0] prev_p = '0;
  bit   [3:0] gexp = '0;
  always @(negedge clk) begin
    for (int ch = 0; ch < 8; ch++) begin
      if (pulse_o[ch] !== prev_p[ch]) begin
        int hit;
        hit = -1;
        for (int i = 0; i < sbq.size(); i++) begin
          if (hit < 0 && sbq[i].ch == ch && sbq[i].val == pulse_o[ch]) hit = i;
        end
        if (hit < 0) begin
          chk(1'b0, "R3", $sformatf("unexpected edge on pulse %0d", ch), int'(pulse_o[ch]), int'(prev_p[ch]));
        end else begin
          chk(sbq[hit].cyc == cyc, sbq[hit].req,
              $sformatf("edge cycle of pulse %0d level %0d", ch, pulse_o[ch]), cyc, sbq[hit].cyc);
          sbq.delete(hit);
        end
      end
    end
    prev_p = pulse_o;
    for (int g = 0; g < 4; g++) begin
      int sch;
      sch = 4 * (g / 2) + (g % 2);
      if (exp_high(sch + 2, cyc - 1))  gexp[g] = 1'b0;
      else if (exp_high(sch, cyc - 1)) gexp[g] = 1'b1;
      chk(gate_o[g] === gexp[g], "R9", $sformatf("gate %0d level", g), int'(gate_o[g]), int'(gexp[g]));
    end
  end

  always @(negedge clk) us_tick = ((cyc + 1) % 9 == 0);

  task automatic wr(logic [1:0] kind, int idx, logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {kind, idx[2:0]}; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(logic [7:0] code, output int s);
    @(negedge clk);
    s = cyc + 1;
    evt_valid = 1'b1; evt_code = code;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain(string req);
    n_cmp++;
    if (sbq.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d expected edges missing, first due cycle %0d, actual 0 expected 0 left",
               req, sbq.size(), sbq[0].cyc);
      sbq.delete();
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int s, s2, t1;
    rst_n = 1'b0; evt_valid = 1'b0; evt_code = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    chk(pulse_o == 8'h00, "R1", "pulses in reset", int'(pulse_o), 0);
    chk(gate_o == 4'h0, "R1", "gates in reset", int'(gate_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: registers reset to code 0, disabled: a code-0 event starts nothing
    send(8'h00, s);
    wait_until(s + 20);
    chk(pulse_o == 8'h00, "R1", "pulses after event on reset config", int'(pulse_o), 0);
    drain("R1");

    // R2 R3 R4 R6: pair 0, code in low byte, upper byte ignored
    wr(2'b00, 0, 16'hAB3A);
    wr(2'b10, 0, 16'd5);
    wr(2'b10, 1, 16'd2);
    wr(2'b01, 0, 16'h0501);
    send(8'h3B, s);
    wait_until(s + 20);
    chk(pulse_o == 8'h00, "R3", "pulses after non-matching code", int'(pulse_o), 0);
    send(8'h3A, s);
    expect_pulse(0, s + 6, 1, "R4");
    expect_pulse(1, s + 3, 7, "R6");
    wait_until(s + 30);
    drain("R2");

    // R6: long length and reserved length code
    wr(2'b01, 0, 16'h0D09);
    send(8'h3A, s);
    expect_pulse(0, s + 6, 73, "R6");
    expect_pulse(1, s + 3, 1, "R6");
    wait_until(s + 95);
    drain("R6");

    // R7: restart while counting
    wr(2'b01, 0, 16'h0001);
    wr(2'b10, 0, 16'd10);
    send(8'h3A, s);
    repeat (3) @(negedge clk);
    send(8'h3A, s2);
    expect_pulse(0, s2 + 11, 1, "R7");
    wait_until(s2 + 30);
    drain("R7");

    // R10: disable mid-count, then events ignored while disabled
    wr(2'b10, 0, 16'd20);
    send(8'h3A, s);
    repeat (4) @(negedge clk);
    wr(2'b01, 0, 16'h0000);
    wait_until(s + 40);
    chk(pulse_o[0] == 1'b0, "R10", "pulse 0 after disable mid-count", int'(pulse_o[0]), 0);
    send(8'h3A, s);
    wait_until(s + 30);
    chk(pulse_o == 8'h00, "R10", "pulses with channel disabled", int'(pulse_o), 0);
    drain("R10");

    // R5: slow timebase on channel 4 (pair 2)
    wr(2'b00, 2, 16'h0055);
    wr(2'b10, 4, 16'd2);
    wr(2'b01, 2, 16'h0003);
    send(8'h55, s);
    t1 = (s / 9 + 1) * 9;
    expect_pulse(4, t1 + 18, 1, "R5");
    wait_until(t1 + 40);
    drain("R5");

    // R8: channel 2 chained from channel 0; pair 1 code also matches but is ignored
    wr(2'b10, 0, 16'd4);
    wr(2'b01, 0, 16'h0001);
    wr(2'b00, 1, 16'h003A);
    wr(2'b10, 2, 16'd6);
    wr(2'b01, 1, 16'h0011);
    send(8'h3A, s);
    expect_pulse(0, s + 5, 1, "R8");
    expect_pulse(2, s + 12, 1, "R8");
    wait_until(s + 30);
    chk(gate_o[0] == 1'b0, "R9", "gate 0 closed by channel 2", int'(gate_o[0]), 0);
    drain("R8");

    // R9: set and clear on the same cycle, clear wins
    wr(2'b01, 1, 16'h0001);
    wr(2'b10, 2, 16'd4);
    send(8'h3A, s);
    expect_pulse(0, s + 5, 1, "R9");
    expect_pulse(2, s + 5, 1, "R9");
    wait_until(s + 7);
    chk(gate_o[0] == 1'b0, "R9", "gate 0 with simultaneous set and clear", int'(gate_o[0]), 0);
    wait_until(s + 20);
    drain("R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule